// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Coherent Snapshot Read

The block holds four independent down-counting timers behind a single-cycle register bus. Each channel counts down from a programmable reload value and reloads on expiry. Every expiry adds one to the channel's 32-bit overflow count and raises that channel's interrupt status. A channel counts only while both the block-wide enable and its own local enable are set. While it is stopped, its counter keeps its value. The inverse of a running count gives software a rising timebase.

A single read cannot return both the count and the overflow total, so the block makes the pair coherent through read order. A read of a channel's overflow register also copies the live count into that channel's holding register. A later read of the current-value register returns that held copy. Software must therefore read the overflow value first and the current value second.

Each channel is controlled by a two-state machine:
- `CH_HALT`: the channel is stopped.
- `CH_RUN`: the channel is counting.

It has three transitions:
- **start** (`CH_HALT` to `CH_RUN`): both enables are seen set, and the counter loads the reload value.
- **stop** (`CH_RUN` to `CH_HALT`): either enable is seen clear, and the counter holds its value.
- **stay**: all other cases.

Top module: `mtimer_bank`

## Requirements
- R1: After reset, every readable register reads 0 except the revision register, and `irq` and `irq_ch` are low.
- R2: Address map. The revision register sits at 0x10.
  - Window 0 holds two registers. At 0x00, bit 0 is the block-wide enable and can be read and written. At 0x10 is the read-only revision, which reads the parameter REV (default 0x00010000).
  - Channel i (0..3) has a window based at 0x20*(i+1). It holds these registers:
    - +0x00 local enable, bit 0;
    - +0x04 reload value, 32 bits;
    - +0x08 held current value;
    - +0x0C overflow count;
    - +0x10 interrupt status, bit 0;
    - +0x14 status clear;
    - +0x18 interrupt mask, bit 0.
  - Any other address reads 0.
  - Writes to the revision, current, overflow and status registers are ignored.
- R3: Read data appears on `rdata` in the cycle after the cycle in which `rd_en` is high, and it stays there until the next read.
- R4: At the first clock edge at which a halted channel sees both enables set, its counter loads the reload value. The overflow count is not changed by this load.
- R5: While a channel runs, each clock edge decrements the counter. At the edge after the counter reaches 0, the counter takes the reload value, the overflow count rises by 1 and status bit 0 is set.
- R6: While either enable is 0, the counter holds its value.
- R7: Reading a channel's overflow register returns the overflow count and copies the live count into the holding register. Reads of the current-value register return that held copy until the next overflow read.
- R8: Writing 1 in bit 0 of the clear register clears status. Writing 0 there has no effect. An expiry in the same cycle wins over the clear.
- R9: `irq_ch[i]` is the channel's status AND its mask bit. `irq` is the OR of all `irq_ch` bits.
- R10: Channels are independent. Writes and reads aimed at one channel leave every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; the result appears on rdata in the next cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_ch | output | 4 | Interrupt of each channel (status AND mask) |
| irq | output | 1 | OR of all channel interrupts |

## Verification
The hardest thing to reach from the ports is a snapshot taken at a known count. The live counter cannot be read, and its value at any moment depends on how many clock edges have passed since the channel started. The bench therefore records the edge on which the enabling write lands. For every overflow read, it computes the count and overflow total that R4 and R5 predict for the edge that captures the snapshot. It then checks that a later current-value read still returns that captured value, while the live counter has moved on. Global disable is used to freeze a channel so that clears and read-only writes can be checked without an expiry racing them.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // register offsets inside one channel window (window size 0x20)
    localparam logic [4:0] OFS_CFG    = 5'h00;
    localparam logic [4:0] OFS_RELOAD = 5'h04;
    localparam logic [4:0] OFS_CUR    = 5'h08;
    localparam logic [4:0] OFS_OVF    = 5'h0C;
    localparam logic [4:0] OFS_STAT   = 5'h10;
    localparam logic [4:0] OFS_CLR    = 5'h14;
    localparam logic [4:0] OFS_MASK   = 5'h18;

    // registers inside window 0
    localparam logic [4:0] OFS_GCTRL  = 5'h00;
    localparam logic [4:0] OFS_REV    = 5'h10;

endpackage

// File: rtl/mtimer_chan.sv
module mtimer_chan
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             wr_cfg,
    input  logic             wr_reload,
    input  logic             wr_clr,
    input  logic             wr_mask,
    input  logic [CNT_W-1:0] wdata,
    input  logic             snap,
    output logic             cfg_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] hold_q,
    output logic [CNT_W-1:0] ovf_q,
    output logic             stat_q,
    output logic             mask_q,
    output logic             irq_o
);

    ch_state_e state_q, state_nx;
    logic      run_en;
    logic      expire;

    assign run_en = glb_en & cfg_q;
    assign expire = (state_q == CH_RUN) && run_en && (cnt_q == '0);
    assign irq_o  = stat_q & mask_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_nx;
    end

    // transitions: start, stop, stay
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_HALT: if (run_en)  state_nx = CH_RUN;
            CH_RUN:  if (!run_en) state_nx = CH_HALT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
            hold_q   <= '0;
            ovf_q    <= '0;
            stat_q   <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            if (wr_cfg)    cfg_q    <= wdata[0];
            if (wr_reload) reload_q <= wdata;
            if (wr_mask)   mask_q   <= wdata[0];
            if (snap)      hold_q   <= cnt_q;

            unique case (state_q)
                CH_HALT: if (run_en) cnt_q <= reload_q;
                CH_RUN: begin
                    if (run_en) cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
                end
            endcase

            if (expire) ovf_q <= ovf_q + 1'b1;

            if (expire)                 stat_q <= 1'b1;
            else if (wr_clr && wdata[0]) stat_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mtimer_rdmux.sv
module mtimer_rdmux
    import mtimer_pkg::*;
#(
    parameter int                NUM_CH = 4,
    parameter int                CNT_W  = 32,
    parameter int                ADDR_W = 8,
    parameter logic [CNT_W-1:0]  REV    = 32'h0001_0000
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          glb_q,
    input  logic [NUM_CH-1:0]             cfg_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  reload_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  hold_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ovf_all,
    input  logic [NUM_CH-1:0]             stat_all,
    input  logic [NUM_CH-1:0]             mask_all,
    output logic [CNT_W-1:0]              rvalue
);

    localparam int WIN_W = ADDR_W - 5;

    logic [WIN_W-1:0] win;
    logic [4:0]       ofs;

    assign win = addr[ADDR_W-1:5];
    assign ofs = addr[4:0];

    always_comb begin
        rvalue = '0;
        if (win == '0) begin
            if (ofs == OFS_GCTRL)    rvalue = CNT_W'(glb_q);
            else if (ofs == OFS_REV) rvalue = REV;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (win == WIN_W'(i + 1)) begin
                    case (ofs)
                        OFS_CFG:    rvalue = CNT_W'(cfg_all[i]);
                        OFS_RELOAD: rvalue = reload_all[i];
                        OFS_CUR:    rvalue = hold_all[i];
                        OFS_OVF:    rvalue = ovf_all[i];
                        OFS_STAT:   rvalue = CNT_W'(stat_all[i]);
                        OFS_MASK:   rvalue = CNT_W'(mask_all[i]);
                        default:    rvalue = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
    import mtimer_pkg::*;
#(
    parameter int                NUM_CH = 4,
    parameter int                CNT_W  = 32,
    parameter int                ADDR_W = 8,
    parameter logic [CNT_W-1:0]  REV    = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq
);

    localparam int WIN_W = ADDR_W - 5;

    logic                         glb_q;
    logic [WIN_W-1:0]             win;
    logic [4:0]                   ofs;
    logic [NUM_CH-1:0]            cfg_all;
    logic [NUM_CH-1:0]            stat_all;
    logic [NUM_CH-1:0]            mask_all;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_all;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CH-1:0][CNT_W-1:0] hold_all;
    logic [NUM_CH-1:0][CNT_W-1:0] ovf_all;
    logic [CNT_W-1:0]             rvalue;

    assign win = addr[ADDR_W-1:5];
    assign ofs = addr[4:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= 1'b0;
            rdata <= '0;
        end else begin
            if (wr_en && win == '0 && ofs == OFS_GCTRL) glb_q <= wdata[0];
            if (rd_en) rdata <= rvalue;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = (win == WIN_W'(i + 1));

        mtimer_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .glb_en    (glb_q),
            .wr_cfg    (wr_en && sel && ofs == OFS_CFG),
            .wr_reload (wr_en && sel && ofs == OFS_RELOAD),
            .wr_clr    (wr_en && sel && ofs == OFS_CLR),
            .wr_mask   (wr_en && sel && ofs == OFS_MASK),
            .wdata     (wdata),
            .snap      (rd_en && sel && ofs == OFS_OVF),
            .cfg_q     (cfg_all[i]),
            .reload_q  (reload_all[i]),
            .cnt_q     (cnt_all[i]),
            .hold_q    (hold_all[i]),
            .ovf_q     (ovf_all[i]),
            .stat_q    (stat_all[i]),
            .mask_q    (mask_all[i]),
            .irq_o     (irq_ch[i])
        );
    end

    assign irq = |irq_ch;

    mtimer_rdmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .REV    (REV)
    ) u_rdmux (
        .addr       (addr),
        .glb_q      (glb_q),
        .cfg_all    (cfg_all),
        .reload_all (reload_all),
        .hold_all   (hold_all),
        .ovf_all    (ovf_all),
        .stat_all   (stat_all),
        .mask_all   (mask_all),
        .rvalue     (rvalue)
    );

endmodule

// File: rtl/mtimer_bank_chk.sv
module mtimer_bank_chk #(
    parameter int                NUM_CH = 4,
    parameter int                CNT_W  = 32,
    parameter int                ADDR_W = 8,
    parameter logic [CNT_W-1:0]  REV    = 32'h0001_0000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [CNT_W-1:0]             rdata,
    input logic                         irq,
    input logic                         glb_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input logic [CNT_W-1:0]             hold0,
    input logic [CNT_W-1:0]             ovf0,
    input logic [NUM_CH-1:0]            stat_all
);

    localparam int WIN_W = ADDR_W - 5;

    logic [WIN_W-1:0] win;
    logic [4:0]       ofs;
    logic             mapped;

    assign win    = addr[ADDR_W-1:5];
    assign ofs    = addr[4:0];
    assign mapped = (ofs[1:0] == 2'b00) &&
                    ((win == '0) ? (ofs == 5'h00 || ofs == 5'h10)
                                 : (int'(win) <= NUM_CH && ofs <= 5'h18));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0));

    // R2
    rev_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8'h10)) |=> (rdata == REV));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_q |=> $stable(cnt_all));

    // R7
    snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8'h2C)) |=> (hold0 == $past(cnt_all[0])));

    // R5
    ovf_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf0 != $past(ovf0)) |-> stat_all[0]);

    // R9
    irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_all != '0));

endmodule

bind mtimer_bank mtimer_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .REV    (REV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .glb_q    (glb_q),
    .cnt_all  (cnt_all),
    .hold0    (hold_all[0]),
    .ovf0     (ovf_all[0]),
    .stat_all (stat_all)
);

// File: tb/mtimer_bank_bench.sv
module mtimer_bank_bench;

    localparam logic [31:0] REV = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_ch;
    logic        irq;

    int     n_chk = 0;
    int     n_fail = 0;
    int     cyc = 0;
    logic   rd_seen = 1'b0;
    bit     done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    mtimer_bank u_mtimer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_ch(irq_ch), .irq(irq)
    );

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= rd_en;
    end

    // monitor: R3, read result valid in the cycle after the strobe
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
            end
        end
    end

    function automatic logic [31:0] exp_cnt(longint r, longint n);
        return 32'(r - ((n - 1) % (r + 1)));
    endfunction

    function automatic logic [31:0] exp_ovf(longint r, longint n);
        return 32'((n - 1) / (r + 1));
    endfunction

    task automatic idle(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic chk(string t, logic [31:0] act, logic [31:0] e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int en0, nf, en1, en2, en3, n;
        logic [31:0] base, frz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h00, 32'h0, "R1 global ctrl");
        rd(8'h10, REV,   "R3 R1 revision");
        rd(8'h20, 32'h0, "R1 ch0 cfg");
        rd(8'h24, 32'h0, "R1 ch0 reload");
        rd(8'h2C, 32'h0, "R1 ch0 overflow");
        rd(8'h28, 32'h0, "R1 ch0 current");
        rd(8'h30, 32'h0, "R1 ch0 status");
        rd(8'h38, 32'h0, "R1 ch0 mask");
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 irq_ch", 32'(irq_ch), 32'h0);

        // R4 R5 R7: ch0 with reload 5
        wr(8'h24, 32'd5);
        wr(8'h20, 32'd1);
        wr(8'h00, 32'd1);
        en0 = cyc;
        rd(8'h00, 32'h1, "R2 global enable readback");
        idle(10);
        n = cyc - en0;
        rd(8'h2C, exp_ovf(5, n), "R5 ch0 overflow count");
        rd(8'h28, exp_cnt(5, n), "R7 ch0 snapshot current");
        idle(3);
        rd(8'h28, exp_cnt(5, n), "R7 ch0 held value unchanged");
        idle(7);
        n = cyc - en0;
        rd(8'h2C, exp_ovf(5, n), "R5 ch0 overflow count 2");
        rd(8'h28, exp_cnt(5, n), "R7 ch0 snapshot current 2");
        rd(8'h30, 32'h1, "R5 ch0 status set");
        chk("R9 irq masked off", 32'(irq), 32'h0);
        wr(8'h38, 32'd1);
        chk("R9 irq unmasked", 32'(irq), 32'h1);
        chk("R9 irq_ch", 32'(irq_ch), 32'h1);

        // R6 global disable freezes
        wr(8'h00, 32'd0);
        nf = cyc - en0;
        idle(2);
        rd(8'h2C, exp_ovf(5, nf), "R6 frozen overflow");
        rd(8'h28, exp_cnt(5, nf), "R6 frozen current");
        idle(5);
        rd(8'h2C, exp_ovf(5, nf), "R6 frozen overflow later");
        rd(8'h28, exp_cnt(5, nf), "R6 frozen current later");

        // R8 clear
        wr(8'h34, 32'd0);
        rd(8'h30, 32'h1, "R8 clear with bit0=0 ignored");
        chk("R8 irq still set", 32'(irq), 32'h1);
        wr(8'h34, 32'd1);
        chk("R9 irq after clear", 32'(irq), 32'h0);
        rd(8'h30, 32'h0, "R8 status cleared");

        // R2 read-only and unmapped
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, REV, "R2 revision read-only");
        wr(8'h28, 32'd123);
        wr(8'h2C, 32'd77);
        wr(8'h30, 32'd1);
        rd(8'h2C, exp_ovf(5, nf), "R2 overflow read-only");
        rd(8'h28, exp_cnt(5, nf), "R2 current read-only");
        rd(8'h30, 32'h0, "R2 status read-only");
        rd(8'h04, 32'h0, "R2 unmapped 0x04");
        rd(8'h3C, 32'h0, "R2 unmapped 0x3C");
        rd(8'hA0, 32'h0, "R2 unmapped 0xA0");
        rd(8'hC0, 32'h0, "R2 unmapped 0xC0");
        rd(8'h22, 32'h0, "R2 unaligned 0x22");

        // R4 reload on enable transition
        base = exp_ovf(5, nf);
        wr(8'h20, 32'd0);
        wr(8'h24, 32'd3);
        wr(8'h20, 32'd1);
        wr(8'h00, 32'd1);
        en1 = cyc;
        idle(1);
        n = cyc - en1;
        rd(8'h2C, base + exp_ovf(3, n), "R4 overflow kept on load");
        rd(8'h28, 32'd3, "R4 counter loads reload");
        idle(6);
        n = cyc - en1;
        rd(8'h2C, base + exp_ovf(3, n), "R5 overflow after reload");
        rd(8'h28, exp_cnt(3, n), "R5 count after reload");

        // R10 independence, R9 OR
        wr(8'h20, 32'd0);
        wr(8'h34, 32'd1);
        chk("R9 irq low after ch0 stop", 32'(irq), 32'h0);
        wr(8'h78, 32'd1);
        wr(8'h64, 32'd2);
        wr(8'h60, 32'd1);
        en2 = cyc;
        idle(5);
        chk("R10 irq_ch only ch2", 32'(irq_ch), 32'h4);
        chk("R9 irq from ch2", 32'(irq), 32'h1);
        n = cyc - en2;
        rd(8'h6C, exp_ovf(2, n), "R10 ch2 overflow");
        rd(8'h68, exp_cnt(2, n), "R10 ch2 current");
        rd(8'h4C, 32'h0, "R10 ch1 overflow untouched");
        rd(8'h48, 32'h0, "R10 ch1 current untouched");
        rd(8'h44, 32'h0, "R10 ch1 reload untouched");

        // R5 full-width reload on ch3
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h80, 32'd1);
        en3 = cyc;
        idle(4);
        n = cyc - en3;
        frz = exp_cnt(64'hFFFF_FFFF, n);
        rd(8'h8C, 32'h0, "R5 ch3 no overflow yet");
        rd(8'h88, frz, "R5 ch3 full-width count");

        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule